// File: doc/BRIEF.md
# Nine-Bit Handshaked Parallel Output Port

This block sits on the I/O side of a simple 8-bit processor bus and sends 9-bit words to a peripheral. Each word is eight data bits plus a flag saying whether the byte is a command or data. The port occupies two neighbouring I/O addresses. The lowest address bit of a write is captured with the byte, so the address the CPU writes to decides whether the byte goes out as a command or as data.

A write raises a request flag that stays set until the peripheral accepts the byte. No timed strobe pulse is used. The peripheral's accept line is asynchronous. It passes through a two-flop synchroniser, and its assertion edge clears the request. A write that arrives while a byte is still pending is dropped, and a sticky overrun bit records it. An 8-bit status word is always present on the read bus. Reading it at either port address clears the overrun bit. All lines toward the peripheral are active low, in the manner of open-collector drivers.

Top module: `ninebit_port`

## Requirements
- R1: After reset the request line `req_n` is high (released), `bus_data_n` is 8'hFF (all released), `bus_cmd_n` is low (command level), and `io_rdata` is 8'h00.
- R2: The port answers only at I/O addresses BASE_ADDR and BASE_ADDR+1, where every address bit except bit 0 must match. A write or read at any other address leaves all outputs and the overrun bit unchanged.
- R3: A write at a port address while not busy latches the byte and address bit 0. From the next cycle `bus_data_n` equals the inverted byte. `bus_cmd_n` equals the latched bit 0: address bit 0 = 0 gives command (line low), and address bit 0 = 1 gives data (line high). `req_n` goes low.
- R4: A write at a port address while `req_n` is low is ignored: `bus_data_n` and `bus_cmd_n` keep their values.
- R5: An ignored write sets the overrun bit, status bit 1. The bit stays set until a status read.
- R6: A status read (`io_rd` at a port address) clears the overrun bit from the next cycle. If an ignored write falls in the same cycle, the bit is set instead.
- R7: A falling edge on `periph_ack_n` (accept asserted) is synchronised by two flops and releases `req_n` at the third rising clock edge after the change. Holding the line low does not clear a later request; a new high-to-low transition is needed.
- R8: The status word `io_rdata` is driven continuously: bit 0 busy (request pending), bit 1 overrun, bit 2 latched address bit 0 (1 = data), bit 3 synchronised accept level (1 = asserted), bits 7:4 zero.
- R9: If a write arrives in the same cycle that an accept edge releases the request, the write is still treated as arriving while busy. It is ignored and sets overrun, and `req_n` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | CPU I/O address |
| io_wdata | input | DATA_W | CPU write byte |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_rd | input | 1 | One-cycle I/O read strobe |
| io_rdata | output | 8 | Status word |
| periph_ack_n | input | 1 | Asynchronous accept from peripheral, active low |
| bus_data_n | output | DATA_W | Data lines toward peripheral, active low |
| bus_cmd_n | output | 1 | Command/data line, low = command |
| req_n | output | 1 | Handshake request line, low = byte pending |

## Verification
Two functions of this block can meet in one clock cycle. The first is an accept edge that releases the request while a new write lands, which tests whether the write is judged against the old busy state. The second is an ignored write that coincides with a status read, which tests whether setting the overrun bit takes priority over clearing it. The bench provokes both by placing the write strobe exactly on the edge where the synchronised accept takes effect, and by raising read and write together while busy. A behavioural model compares every output on every clock, and directed checks confirm that `req_n` is released, the data lines are unchanged and overrun reads back as 1.

// File: rtl/ninebit_pkg.sv
package ninebit_pkg;
   localparam int STAT_W = 8;

   typedef struct packed {
      logic [3:0] rsvd;
      logic       ack_lvl;
      logic       cd;
      logic       ovr;
      logic       busy;
   } stat_t;
endpackage

// File: rtl/ninebit_sync.sv
module ninebit_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 2) else $error("ninebit_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ninebit_decode.sv
module ninebit_decode #(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              wr_hit,
   output logic              rd_hit,
   output logic              sel_lsb
);
   initial assert (ADDR_W >= 2) else $error("ninebit_decode: ADDR_W too small");
   initial assert (BASE_ADDR[0] == 1'b0) else $error("ninebit_decode: BASE_ADDR must be even");

   logic match;
   assign match   = (addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
   assign wr_hit  = wr & match;
   assign rd_hit  = rd & match;
   assign sel_lsb = addr[0];
endmodule

// File: rtl/ninebit_hshk.sv
module ninebit_hshk #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lsb,
   input  logic              ack_rise,
   output logic              busy,
   output logic              ovr,
   output logic [DATA_W-1:0] data_q,
   output logic              cd_q
);
   logic take, drop;

   assign take = wr_hit & ~busy;
   assign drop = wr_hit &  busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         cd_q   <= 1'b0;
      end else if (take) begin
         data_q <= wdata;
         cd_q   <= lsb;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        busy <= 1'b0;
      else if (take)     busy <= 1'b1;
      else if (ack_rise) busy <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ovr <= 1'b0;
      else if (drop)   ovr <= 1'b1;
      else if (rd_hit) ovr <= 1'b0;
   end
endmodule

// File: rtl/ninebit_port.sv
module ninebit_port #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   input  logic              periph_ack_n,
   output logic [DATA_W-1:0] bus_data_n,
   output logic              bus_cmd_n,
   output logic              req_n
);
   import ninebit_pkg::*;

   initial assert (DATA_W >= 1) else $error("ninebit_port: DATA_W must be positive");

   logic wr_hit, rd_hit, lsb;
   logic ack_lvl, ack_prev, ack_rise;
   logic busy, ovr, cd_q;
   logic [DATA_W-1:0] data_q;
   stat_t stat;

   ninebit_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr(io_addr), .wr(io_wr), .rd(io_rd),
      .wr_hit(wr_hit), .rd_hit(rd_hit), .sel_lsb(lsb)
   );

   ninebit_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(~periph_ack_n), .q(ack_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ack_prev <= 1'b0;
      else        ack_prev <= ack_lvl;
   end
   assign ack_rise = ack_lvl & ~ack_prev;

   ninebit_hshk #(.DATA_W(DATA_W)) u_hs (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit),
      .wdata(io_wdata), .lsb(lsb), .ack_rise(ack_rise),
      .busy(busy), .ovr(ovr), .data_q(data_q), .cd_q(cd_q)
   );

   always_comb begin
      stat         = '0;
      stat.busy    = busy;
      stat.ovr     = ovr;
      stat.cd      = cd_q;
      stat.ack_lvl = ack_lvl;
   end

   assign io_rdata   = stat;
   assign bus_data_n = ~data_q;
   assign bus_cmd_n  = cd_q;
   assign req_n      = ~busy;
endmodule

// File: rtl/ninebit_port_chk.sv
module ninebit_port_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_rdata,
   input logic              periph_ack_n,
   input logic [DATA_W-1:0] bus_data_n,
   input logic              bus_cmd_n,
   input logic              req_n
);
   logic hit;
   assign hit = (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);

   // R3
   write_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit && req_n) |=> (!req_n && bus_cmd_n == $past(io_addr[0])
                                   && bus_data_n == ~$past(io_wdata)));

   // R4
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit && !req_n) |=> ($stable(bus_data_n) && $stable(bus_cmd_n)));

   // R5
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit && !req_n) |=> io_rdata[1]);

   // R6
   overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && hit && !(io_wr && !req_n)) |=> !io_rdata[1]);

   // R2
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !hit && req_n) |=> req_n);

   // R8
   status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdata[7:4] == 4'b0000);
endmodule

bind ninebit_port ninebit_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .BASE_ADDR(BASE_ADDR)
) u_chk (.*);

// File: tb/ninebit_port_tb.sv
`timescale 1ns/1ps
module ninebit_port_tb;
   localparam logic [7:0] BASE = 8'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = 8'h00;
   logic [7:0] io_wdata = 8'h00;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic       periph_ack_n = 1'b1;
   logic [7:0] io_rdata;
   logic [7:0] bus_data_n;
   logic       bus_cmd_n;
   logic       req_n;

   int nchk = 0;
   int nerr = 0;

   always #2.5 clk = ~clk;

   ninebit_port #(.ADDR_W(8), .DATA_W(8), .SYNC_STAGES(2), .BASE_ADDR(BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .periph_ack_n(periph_ack_n),
      .bus_data_n(bus_data_n), .bus_cmd_n(bus_cmd_n), .req_n(req_n)
   );

   // behavioural reference
   bit       m_busy, m_ovr, m_cd;
   bit [7:0] m_data;
   bit       hist [3];

   always @(posedge clk) begin
      bit port_w, port_r, edge_seen, dropped;
      if (!rst_n) begin
         m_busy = 0; m_ovr = 0; m_cd = 0; m_data = 0;
         hist[0] = 0; hist[1] = 0; hist[2] = 0;
      end else begin
         port_w    = io_wr && ((io_addr >> 1) == (BASE >> 1));
         port_r    = io_rd && ((io_addr >> 1) == (BASE >> 1));
         edge_seen = hist[1] && !hist[2];
         dropped   = port_w && m_busy;
         if (port_w && !m_busy) begin
            m_data = io_wdata; m_cd = io_addr[0]; m_busy = 1;
         end else if (edge_seen) m_busy = 0;
         if (dropped) m_ovr = 1;
         else if (port_r) m_ovr = 0;
         hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = !periph_ack_n;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(bus_data_n == ~m_data, "R3 model data lines", bus_data_n, ~m_data);
         chk(bus_cmd_n == m_cd, "R3 model cmd line", bus_cmd_n, m_cd);
         chk(req_n == !m_busy, "R7 model request", req_n, !m_busy);
         chk(io_rdata == {4'b0, hist[1], m_cd, m_ovr, m_busy}, "R8 model status",
             io_rdata, {4'b0, hist[1], m_cd, m_ovr, m_busy});
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic ack_pulse();
      periph_ack_n = 1'b0;
      repeat (4) @(negedge clk);
      periph_ack_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_n == 1'b1, "R1 req_n", req_n, 1);
      chk(bus_data_n == 8'hFF, "R1 data lines", bus_data_n, 8'hFF);
      chk(bus_cmd_n == 1'b0, "R1 cmd level", bus_cmd_n, 0);
      chk(io_rdata == 8'h00, "R1 status", io_rdata, 0);

      // R3 command write
      wr(BASE, 8'hA5);
      chk(bus_data_n == 8'h5A, "R3 data", bus_data_n, 8'h5A);
      chk(bus_cmd_n == 1'b0, "R3 command level", bus_cmd_n, 0);
      chk(req_n == 1'b0, "R3 request", req_n, 0);
      chk(io_rdata == 8'h01, "R8 status busy", io_rdata, 8'h01);

      // R4 / R5 write while busy
      wr(BASE + 8'd1, 8'h3C);
      chk(bus_data_n == 8'h5A, "R4 data kept", bus_data_n, 8'h5A);
      chk(bus_cmd_n == 1'b0, "R4 cmd kept", bus_cmd_n, 0);
      chk(io_rdata[1] == 1'b1, "R5 overrun set", io_rdata[1], 1);
      @(negedge clk);
      chk(io_rdata[1] == 1'b1, "R5 overrun sticky", io_rdata[1], 1);

      // R2 read elsewhere keeps overrun
      rd(BASE + 8'd2);
      chk(io_rdata[1] == 1'b1, "R2 foreign read", io_rdata[1], 1);
      // R6 status read clears
      rd(BASE + 8'd1);
      chk(io_rdata[1] == 1'b0, "R6 overrun cleared", io_rdata[1], 0);

      // R7 accept timing
      periph_ack_n = 1'b0;
      @(negedge clk);
      chk(req_n == 1'b0, "R7 held edge1", req_n, 0);
      @(negedge clk);
      chk(req_n == 1'b0, "R7 held edge2", req_n, 0);
      chk(io_rdata[3] == 1'b1, "R8 ack level", io_rdata[3], 1);
      @(negedge clk);
      chk(req_n == 1'b1, "R7 released edge3", req_n, 1);

      // R3 data write while accept still held; R7 no retrigger
      wr(BASE + 8'd1, 8'h3C);
      chk(bus_data_n == 8'hC3, "R3 data byte", bus_data_n, 8'hC3);
      chk(bus_cmd_n == 1'b1, "R3 data level", bus_cmd_n, 1);
      repeat (5) @(negedge clk);
      chk(req_n == 1'b0, "R7 held low no retrigger", req_n, 0);
      periph_ack_n = 1'b1;
      repeat (4) @(negedge clk);
      ack_pulse();
      chk(req_n == 1'b1, "R7 new edge releases", req_n, 1);

      // R2 foreign write
      wr(BASE + 8'd2, 8'h77);
      chk(req_n == 1'b1, "R2 foreign write req", req_n, 1);
      chk(bus_data_n == 8'hC3, "R2 foreign write data", bus_data_n, 8'hC3);
      wr(BASE - 8'd1, 8'h11);
      chk(req_n == 1'b1, "R2 lower neighbour", req_n, 1);

      // R9 write on releasing edge
      wr(BASE, 8'h0F);
      periph_ack_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      io_addr = BASE + 8'd1; io_wdata = 8'hEE; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      chk(req_n == 1'b1, "R9 released", req_n, 1);
      chk(io_rdata[1] == 1'b1, "R9 overrun", io_rdata[1], 1);
      chk(bus_data_n == 8'hF0, "R9 data kept", bus_data_n, 8'hF0);
      periph_ack_n = 1'b1;
      repeat (4) @(negedge clk);
      rd(BASE);

      // R6 set wins over clear
      wr(BASE, 8'h55);
      io_addr = BASE; io_wdata = 8'h99; io_wr = 1'b1; io_rd = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      chk(io_rdata[1] == 1'b1, "R6 set wins", io_rdata[1], 1);
      ack_pulse();

      // mixed traffic compared against the model every clock
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 99);
         io_addr  = BASE - 8'd1 + 8'($urandom_range(0, 3));
         io_wdata = 8'($urandom);
         io_wr    = (r < 25);
         io_rd    = (r >= 80);
         if ($urandom_range(0, 5) == 0) periph_ack_n = ~periph_ack_n;
         @(negedge clk);
      end
      io_wr = 1'b0; io_rd = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule